// File: doc/BRIEF.md
# Vector Floating-Point Special-Case Resolver

This block sits beside the arithmetic datapath of a four-lane single-precision vector unit. It inspects the operands of each lane for the current operation and works out whether the lane result must be replaced. The replacement is either a quieted copy of an input NaN or the default NaN 32'h7FC0_0000. When a replacement applies, the lane's override flag is high and the override value carries the word that must be written in place of the datapath result. When no replacement applies, the flag is low and the downstream arithmetic result is used unchanged.

For maximum and minimum the resolver produces the complete result itself, so the override flag for those operations is always high. The add, multiply and transcendental datapaths and the exception flags are not part of this block. The one arithmetic output it reads is the fused multiply result, which it needs so that a NaN raised inside that arithmetic can be replaced by the default NaN. The block is purely combinational.

Top module: `vfp_special_resolve`

## Requirements
- R1: Each of the 4 lanes (lane k occupies bits [32k+31:32k] of every vector port) is resolved from its own operands only, and all lanes share one `op_sel`.
- R2: For add (0), subtract (1), multiply-add (2), negative multiply-subtract (3), max (4) and min (5), a NaN in `src_a` wins and gives a quieted copy of it. Otherwise a NaN in `src_b` does the same. Otherwise, for codes 2 and 3 only, a NaN in `src_c` does the same. Quieting sets fraction bit 22 and keeps every other bit. `src_c` has no effect for codes 0, 1, 4 and 5.
- R3: For add (0), two infinities of opposite sign give the default NaN 32'h7FC0_0000, and two infinities of the same sign give no override.
- R4: For subtract (1), two infinities of the same sign give the default NaN, and two infinities of opposite sign give no override.
- R5: For codes 2 and 3 (result a×c+b, or its negation with b subtracted), an infinity times a zero in either order of a and c gives the default NaN. An input NaN takes priority over this case.
- R6: For codes 2 and 3, when there is no input NaN and `arith_res` for the lane is a NaN, the default NaN is forced.
- R7: For reciprocal square-root estimate (6), a non-NaN `src_b` that is negative and nonzero, including negative infinity, gives the default NaN. Negative zero gives no override.
- R8: The unary codes 6 to 10 (rsqrt, reciprocal, exp2, log2, round) read only `src_b`. A NaN there gives a quieted copy of it, and `src_a` and `src_c` have no effect.
- R9: For max (4) and min (5), the override flag is always high. With no NaN input, the value is the larger (for max) or smaller (for min) of a and b.
- R10: For max and min, operands that compare equal, including +0 against -0, return `src_a`.
- R11: Codes 11 to 15 never raise an override.
- R12: Whenever the override flag of a lane is low, its override value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code shared by all lanes |
| src_a | input | 128 | Operand a per lane (multiplicand for fused ops) |
| src_b | input | 128 | Operand b per lane (addend for fused ops, sole input for unary ops) |
| src_c | input | 128 | Operand c per lane (multiplier for fused ops) |
| arith_res | input | 128 | Datapath result per lane, read for the fused ops only |
| ovr_en | output | 4 | Per-lane override flag |
| ovr_val | output | 128 | Per-lane override value, zero when the flag is low |

## Verification
The bench targets NaN priority with several NaN operands present at once. A resolver with the wrong order would return the payload of b or c instead of a. It checks that infinities of like and unlike sign are caught for add and for subtract, where swapping the sign test between the two operations misfires on one of them. It also covers the fused invalid case against an input NaN, an arithmetic-raised NaN, and rsqrt of -0 against -infinity. For max and min it covers negative operands and signed zeros, where a plain unsigned compare of the encodings picks the wrong operand.

// File: rtl/vfp_res_pkg.sv
// Package: shared widths, operation codes and class record for the
// vector FP special-case resolver. Assumes IEEE-754 binary32 layout.
package vfp_res_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MADD  = 4'd2,
        OP_NMSUB = 4'd3,
        OP_MAX   = 4'd4,
        OP_MIN   = 4'd5,
        OP_RSQRT = 4'd6,
        OP_RECIP = 4'd7,
        OP_EXP2  = 4'd8,
        OP_LOG2  = 4'd9,
        OP_ROUND = 4'd10
    } vfp_op_e;

    typedef struct packed {
        logic nan;
        logic inf;
        logic zero;
        logic neg;
    } fp_class_t;

    localparam logic [FP_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

endpackage

// File: rtl/vfp_classify.sv
// Module: classifies one binary32 word as NaN, infinity, zero and negative,
// and produces its quieted form (quiet bit forced, all else kept).
// Assumes: purely combinational, no denormal special handling needed.
module vfp_classify
    import vfp_res_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls,
    output logic [FP_W-1:0] quiet
);

    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    // Decode exponent and fraction fields into class bits.
    always_comb begin
        exp_ones  = &val[FP_W-2 -: EXP_W];
        exp_zero  = ~|val[FP_W-2 -: EXP_W];
        frac_nz   = |val[FRAC_W-1:0];
        cls.nan   = exp_ones & frac_nz;
        cls.inf   = exp_ones & ~frac_nz;
        cls.zero  = exp_zero & ~frac_nz;
        cls.neg   = val[FP_W-1];
    end

    // Force the quiet bit while keeping sign and the rest of the payload.
    always_comb begin
        quiet       = val;
        quiet[QBIT] = 1'b1;
    end

endmodule

// File: rtl/vfp_order_pick.sv
// Module: returns the larger or smaller of two non-NaN binary32 values.
// Assumes: callers have filtered NaNs; equal values (incl. +0/-0) give a.
module vfp_order_pick
    import vfp_res_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  logic            want_max,
    output logic [FP_W-1:0] pick
);

    logic [FP_W-1:0] key_a;
    logic [FP_W-1:0] key_b;
    logic            both_zero;
    logic            b_above;
    logic            b_below;

    // Map each encoding onto an unsigned key that sorts like the real value.
    always_comb begin
        key_a = op_a[FP_W-1] ? ~op_a : {1'b1, op_a[FP_W-2:0]};
        key_b = op_b[FP_W-1] ? ~op_b : {1'b1, op_b[FP_W-2:0]};
    end

    // Compare keys; signed zeros are treated as equal.
    always_comb begin
        both_zero = ~|op_a[FP_W-2:0] & ~|op_b[FP_W-2:0];
        b_above   = ~both_zero & (key_b > key_a);
        b_below   = ~both_zero & (key_b < key_a);
        if (want_max) pick = b_above ? op_b : op_a;
        else          pick = b_below ? op_b : op_a;
    end

endmodule

// File: rtl/vfp_lane_resolve.sv
// Module: special-case resolver for one lane. Decides override flag and
// value from the operand classes and the operation code.
// Assumes: fused ops compute a*c+b (or its negated subtract form), unary
// ops read operand b only, and arith is the datapath word for this lane.
module vfp_lane_resolve
    import vfp_res_pkg::*;
(
    input  logic [3:0]      op,
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic [FP_W-1:0] c,
    input  logic [FP_W-1:0] arith,
    output logic            en,
    output logic [FP_W-1:0] val
);

    localparam int NSRC = 4;

    logic [FP_W-1:0] srcs   [NSRC];
    fp_class_t       cls    [NSRC];
    logic [FP_W-1:0] quiets [NSRC];
    logic [FP_W-1:0] ordered;
    logic            is_max;
    vfp_op_e         opc;

    // Gather the operands so one classifier per source can be generated.
    always_comb begin
        srcs[0] = a;
        srcs[1] = b;
        srcs[2] = c;
        srcs[3] = arith;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_cls
        vfp_classify u_cls (
            .val   (srcs[s]),
            .cls   (cls[s]),
            .quiet (quiets[s])
        );
    end

    // Select max or min ordering from the opcode.
    always_comb begin
        opc    = vfp_op_e'(op);
        is_max = (opc == OP_MAX);
    end

    vfp_order_pick u_pick (
        .op_a     (a),
        .op_b     (b),
        .want_max (is_max),
        .pick     (ordered)
    );

    // Per-opcode priority chain: NaN inputs first, then invalid combinations.
    always_comb begin
        en  = 1'b0;
        val = '0;
        case (opc)
            OP_ADD, OP_SUB: begin
                if (cls[0].nan) begin
                    en = 1'b1; val = quiets[0];
                end else if (cls[1].nan) begin
                    en = 1'b1; val = quiets[1];
                end else if (cls[0].inf && cls[1].inf &&
                             ((cls[0].neg != cls[1].neg) == (opc == OP_ADD))) begin
                    en = 1'b1; val = DEFAULT_NAN;
                end
            end
            OP_MADD, OP_NMSUB: begin
                if (cls[0].nan) begin
                    en = 1'b1; val = quiets[0];
                end else if (cls[1].nan) begin
                    en = 1'b1; val = quiets[1];
                end else if (cls[2].nan) begin
                    en = 1'b1; val = quiets[2];
                end else if ((cls[0].inf && cls[2].zero) ||
                             (cls[0].zero && cls[2].inf) || cls[3].nan) begin
                    en = 1'b1; val = DEFAULT_NAN;
                end
            end
            OP_MAX, OP_MIN: begin
                en = 1'b1;
                if (cls[0].nan)      val = quiets[0];
                else if (cls[1].nan) val = quiets[1];
                else                 val = ordered;
            end
            OP_RSQRT: begin
                if (cls[1].nan) begin
                    en = 1'b1; val = quiets[1];
                end else if (cls[1].neg && !cls[1].zero) begin
                    en = 1'b1; val = DEFAULT_NAN;
                end
            end
            OP_RECIP, OP_EXP2, OP_LOG2, OP_ROUND: begin
                if (cls[1].nan) begin
                    en = 1'b1; val = quiets[1];
                end
            end
            default: begin
                en  = 1'b0;
                val = '0;
            end
        endcase
    end

    // Guards on the lane outputs against operands and operation.
    always_comb begin
        a_r12_idle_zero: assert (en || (val == '0))
            else $error("lane override value not zero while idle");
        if (op > 4'd10) begin
            a_r11_unknown_idle: assert (!en)
                else $error("override raised for unused opcode");
        end
        if ((opc == OP_MAX || opc == OP_MIN) && !cls[0].nan && !cls[1].nan) begin
            a_r9_minmax_member: assert (en && (val == a || val == b))
                else $error("min/max result is neither operand");
        end
        if (en && (&val[FP_W-2 -: EXP_W]) && (|val[FRAC_W-1:0])) begin
            a_r2_quiet_out: assert (val[QBIT])
                else $error("signalling NaN on override output");
        end
        if (opc == OP_RSQRT && en && !cls[1].nan) begin
            a_r7_rsqrt_dnan: assert (val == DEFAULT_NAN)
                else $error("rsqrt override is not the default NaN");
        end
        if (opc == OP_ADD && cls[0].inf && cls[1].inf && (a[FP_W-1] != b[FP_W-1])) begin
            a_r3_add_inf_clash: assert (en && val == DEFAULT_NAN)
                else $error("add of opposite infinities not replaced");
        end
    end

endmodule

// File: rtl/vfp_special_resolve.sv
// Module: top of the vector FP special-case resolver; one lane resolver
// per vector lane, all driven by the same operation code.
// Assumes: lane k occupies bits [FP_W*k +: FP_W] of every vector port.
module vfp_special_resolve
    import vfp_res_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * FP_W
) (
    input  logic [3:0]       op_sel,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] src_c,
    input  logic [VEC_W-1:0] arith_res,
    output logic [LANES-1:0] ovr_en,
    output logic [VEC_W-1:0] ovr_val
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vfp_lane_resolve u_lane (
            .op    (op_sel),
            .a     (src_a[FP_W*k +: FP_W]),
            .b     (src_b[FP_W*k +: FP_W]),
            .c     (src_c[FP_W*k +: FP_W]),
            .arith (arith_res[FP_W*k +: FP_W]),
            .en    (ovr_en[k]),
            .val   (ovr_val[FP_W*k +: FP_W])
        );
    end

endmodule

// File: tb/test_vfp_special_resolve.sv
// Bench: walks a vector table (one case per lane, rotating lanes, other
// lanes filled with 1.0 operands), then directed idle and mixed-lane tests.
module test_vfp_special_resolve;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int W = 32;

    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] M1   = 32'hBF80_0000;
    localparam logic [31:0] M2   = 32'hC000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] SN1  = 32'h7F80_0001;
    localparam logic [31:0] QN1  = 32'h7FC0_0001;
    localparam logic [31:0] SNN  = 32'hFF81_2345;
    localparam logic [31:0] QNN  = 32'hFFC1_2345;
    localparam logic [31:0] DN   = 32'h7FC0_0000;

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] r;
        logic        en;
        logic [31:0] v;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  4'd0,  SN1, ONE, ONE, TWO, 1'b1, QN1},          // R2 a NaN
        '{8'd2,  4'd0,  ONE, SNN, ONE, TWO, 1'b1, QNN},          // R2 b NaN
        '{8'd2,  4'd0,  SN1, SNN, ONE, TWO, 1'b1, QN1},          // R2 a over b
        '{8'd2,  4'd0,  ONE, ONE, SN1, TWO, 1'b0, 32'h0},        // R2 c ignored by add
        '{8'd3,  4'd0,  PINF, NINF, ONE, TWO, 1'b1, DN},         // R3
        '{8'd3,  4'd0,  NINF, NINF, ONE, TWO, 1'b0, 32'h0},      // R3 same sign
        '{8'd4,  4'd1,  PINF, PINF, ONE, TWO, 1'b1, DN},         // R4
        '{8'd4,  4'd1,  NINF, NINF, ONE, TWO, 1'b1, DN},         // R4
        '{8'd4,  4'd1,  PINF, NINF, ONE, TWO, 1'b0, 32'h0},      // R4 opposite
        '{8'd5,  4'd2,  PINF, ONE, PZ, TWO, 1'b1, DN},           // R5 inf*0
        '{8'd5,  4'd2,  NZ, ONE, NINF, TWO, 1'b1, DN},           // R5 0*inf
        '{8'd5,  4'd3,  PZ, ONE, PINF, TWO, 1'b1, DN},           // R5 nmsub
        '{8'd5,  4'd2,  PINF, SN1, PZ, TWO, 1'b1, QN1},          // R5 NaN first
        '{8'd5,  4'd3,  PINF, ONE, PINF, TWO, 1'b0, 32'h0},      // R5 inf*inf ok
        '{8'd6,  4'd2,  ONE, ONE, ONE, 32'hFFC0_0000, 1'b1, DN}, // R6
        '{8'd6,  4'd3,  ONE, ONE, ONE, 32'h7F80_0042, 1'b1, DN}, // R6
        '{8'd2,  4'd2,  ONE, ONE, 32'h7F80_0005, TWO, 1'b1, 32'h7FC0_0005}, // R2 c
        '{8'd2,  4'd2,  ONE, 32'h7F80_0009, 32'h7F80_0005, TWO, 1'b1, 32'h7FC0_0009}, // R2 b over c
        '{8'd7,  4'd6,  ONE, M1, ONE, TWO, 1'b1, DN},            // R7
        '{8'd7,  4'd6,  ONE, NZ, ONE, TWO, 1'b0, 32'h0},         // R7 -0
        '{8'd7,  4'd6,  ONE, NINF, ONE, TWO, 1'b1, DN},          // R7 -inf
        '{8'd8,  4'd6,  ONE, SNN, ONE, TWO, 1'b1, QNN},          // R8 rsqrt NaN
        '{8'd8,  4'd7,  SN1, ONE, SNN, TWO, 1'b0, 32'h0},        // R8 a,c ignored
        '{8'd8,  4'd8,  ONE, SN1, ONE, TWO, 1'b1, QN1},          // R8 exp2
        '{8'd8,  4'd9,  ONE, 32'h7FC0_ABCD, ONE, TWO, 1'b1, 32'h7FC0_ABCD}, // R8 log2
        '{8'd8,  4'd10, ONE, NINF, ONE, TWO, 1'b0, 32'h0},       // R8 round inf
        '{8'd9,  4'd4,  ONE, TWO, ONE, TWO, 1'b1, TWO},          // R9
        '{8'd9,  4'd4,  M1, M2, ONE, TWO, 1'b1, M1},             // R9 negatives
        '{8'd9,  4'd5,  M1, M2, ONE, TWO, 1'b1, M2},             // R9
        '{8'd9,  4'd5,  TWO, NINF, ONE, TWO, 1'b1, NINF},        // R9
        '{8'd9,  4'd5,  M1, ONE, SN1, TWO, 1'b1, M1},            // R9 c ignored
        '{8'd9,  4'd4,  ONE, SN1, ONE, TWO, 1'b1, QN1},          // R9 NaN b
        '{8'd9,  4'd4,  SNN, SN1, ONE, TWO, 1'b1, QNN},          // R9 NaN a first
        '{8'd10, 4'd4,  PZ, NZ, ONE, TWO, 1'b1, PZ},             // R10
        '{8'd10, 4'd5,  NZ, PZ, ONE, TWO, 1'b1, NZ},             // R10
        '{8'd11, 4'd11, SN1, SNN, SN1, SN1, 1'b0, 32'h0},        // R11
        '{8'd12, 4'd0,  ONE, TWO, ONE, TWO, 1'b0, 32'h0}         // R12
    };

    logic                 clk;
    logic [3:0]           op_sel;
    logic [LANES*W-1:0]   src_a, src_b, src_c, arith_res;
    logic [LANES-1:0]     ovr_en;
    logic [LANES*W-1:0]   ovr_val;

    int errors;
    int checks;
    bit done;

    vfp_special_resolve i_vfp_special_resolve (
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .src_c     (src_c),
        .arith_res (arith_res),
        .ovr_en    (ovr_en),
        .ovr_val   (ovr_val)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_lane(input int req, input int lane,
                              input logic exp_en, input logic [31:0] exp_v);
        checks++;
        if (ovr_en[lane] !== exp_en || ovr_val[W*lane +: W] !== exp_v) begin
            errors++;
            $display("FAIL R%0d lane %0d: got en=%0b val=%08h, expected en=%0b val=%08h",
                     req, lane, ovr_en[lane], ovr_val[W*lane +: W], exp_en, exp_v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        errors = 0;
        checks = 0;
        done   = 1'b0;
        op_sel = 4'd0;
        src_a = '0; src_b = '0; src_c = '0; arith_res = '0;
        @(negedge clk);
        #1;
        // R12: zero operands under add raise nothing on any lane.
        for (int k = 0; k < LANES; k++) check_lane(12, k, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VECS[i].op;
            for (int k = 0; k < LANES; k++) begin
                if (k == i % LANES) begin
                    src_a[W*k +: W] = VECS[i].a;
                    src_b[W*k +: W] = VECS[i].b;
                    src_c[W*k +: W] = VECS[i].c;
                    arith_res[W*k +: W] = VECS[i].r;
                end else begin
                    src_a[W*k +: W] = ONE;
                    src_b[W*k +: W] = ONE;
                    src_c[W*k +: W] = ONE;
                    arith_res[W*k +: W] = TWO;
                end
            end
            #(CLK_PERIOD/4);
            for (int k = 0; k < LANES; k++) begin
                if (k == i % LANES)
                    check_lane(VECS[i].req, k, VECS[i].en, VECS[i].v);
                else if (VECS[i].op == 4'd4 || VECS[i].op == 4'd5)
                    check_lane(1, k, 1'b1, ONE);   // R1 filler lanes under min/max
                else
                    check_lane(1, k, 1'b0, 32'h0); // R1 filler lanes idle
            end
        end

        // R1: four different outcomes under one add in the same cycle.
        @(negedge clk);
        op_sel = 4'd0;
        src_a = {ONE, ONE, PINF, SN1};
        src_b = {SNN, ONE, NINF, ONE};
        src_c = {ONE, ONE, ONE, ONE};
        arith_res = {TWO, TWO, TWO, TWO};
        #(CLK_PERIOD/4);
        check_lane(1, 0, 1'b1, QN1);
        check_lane(1, 1, 1'b1, DN);
        check_lane(1, 2, 1'b0, 32'h0);
        check_lane(1, 3, 1'b1, QNN);

        // R4: same pattern under subtract flips the infinity lane.
        @(negedge clk);
        op_sel = 4'd1;
        #(CLK_PERIOD/4);
        check_lane(4, 1, 1'b0, 32'h0);
        check_lane(4, 0, 1'b1, QN1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule